// File: doc/BRIEF.md
# Edge-Compare Multichannel PWM Generator

This block produces several pulse-width modulated lines from one shared timebase. A prescaler divides the clock into steps. A period counter advances once per step and returns to zero after it reaches the programmed period. Every channel uses this one counter, so the period is common to the whole block and cannot differ between channels.

A channel has no duty-cycle setting. Its waveform comes from two compare values. When the counter reaches the set-point the line goes high, and when it reaches the clear-point the line goes low. When the two values are equal, the line inverts once per period. One exception is decoded on purpose: a clear-point of zero together with a set-point equal to the period gives a line that stays low.

Software programs the block through a simple write/read register port. The block is built in one of two modes, chosen by a parameter. In direct mode, register writes change the waveform at once. In staged mode, writes fill a staging copy. A commit command then loads the staging copy into the live registers at the next period boundary.

Top module: `edgepwm_top`

## Requirements
- R1: After reset all channel lines are low, every register reads 0, the commit flag reads 0 and both counters are 0.
- R2: Prescaler and period counter are shared by all channels. One waveform period lasts (prescale+1)*(period+1) clocks, the prescaler restarts at 0 after each step and the period counter restarts at 0 after its wrap.
- R3: On the step during which the counter equals the set-point, the line goes high at that clock edge. On the step during which it equals the clear-point, the line goes low. Between steps the line holds. With set-point below clear-point the line is high for (clear-set) steps per period; with set-point above clear-point it is high for (period+1-(set-clear)) steps.
- R4: Equal set-point and clear-point invert the line once per period, which gives a 50% waveform whose period is twice the programmed one.
- R5: A clear-point of 0 together with a set-point equal to the live period keeps the line low.
- R6: Each channel has its own enable bit (bit i of the enable register is channel i). The cycle after a channel's enable bit is 0, its line is low.
- R7: With SHADOW_EN=0, writes to prescale, period and compare registers act at once, even in the middle of a period, and the commit register reads 0.
- R8: With SHADOW_EN=1, writes to prescale, period and compare registers change only the staging copy. The live values change only at a period wrap that follows a commit request.
- R9: Writing 1 to bit 0 of the commit register sets a flag that reads 1 until the staged values have been copied at the next period wrap, then reads 0. If a commit write and a wrap fall in the same cycle, the write wins and the flag stays set.
- R10: Register addresses: 0 prescale, 1 period, 2 enable mask, 3 commit (bit 0), 4+2*i set-point of channel i, 5+2*i clear-point of channel i. Reads return the last written value; in staged mode this is the staging copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | VAL_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | VAL_W | Read data, combinational from rd_addr |
| pwm_out | output | NUM_CH | One PWM line per channel |

## Verification
A table drives compare pairs through both build modes. The pairs cover set-point below clear-point, set-point above clear-point (the high time wraps through zero), equal values, and the zero-duty pair. The bench counts high cycles and rising edges over a window of whole periods. High cycles separate the three edge orderings and the special zero case. Edge counts separate the toggle pattern, with half as many edges as a normal waveform, from a normal waveform.

Directed runs check three more behaviours. Uncommitted writes change the direct-mode instance but not the staged-mode instance. A second channel has the same edge count as the first, which shows the timebase is shared. Clearing one enable bit silences only that channel.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;

  // Register address layout
  localparam int ADDR_PRESCALE  = 0;
  localparam int ADDR_PERIOD    = 1;
  localparam int ADDR_ENABLE    = 2;
  localparam int ADDR_COMMIT    = 3;
  localparam int ADDR_EDGE_BASE = 4;

  // Address of a channel's set-point (falling=0) or clear-point (falling=1)
  function automatic int edge_addr(input int ch, input bit falling);
    return ADDR_EDGE_BASE + 2 * ch + (falling ? 1 : 0);
  endfunction

  // Next line level on a step, from the present level and compare hits
  function automatic logic next_level(input logic cur, input logic hit_set,
                                      input logic hit_clr, input logic zero_duty);
    if (zero_duty)             return 1'b0;
    if (hit_set && hit_clr)    return ~cur;
    if (hit_set)               return 1'b1;
    if (hit_clr)               return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/edgepwm_regs.sv
module edgepwm_regs
  import edgepwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int VAL_W     = 8,
  parameter int ADDR_W    = 4,
  parameter bit SHADOW_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VAL_W-1:0]  rd_data,
  input  logic              wrap,
  output logic [VAL_W-1:0]  act_pre,
  output logic [VAL_W-1:0]  act_per,
  output logic [VAL_W-1:0]  act_set [NUM_CH],
  output logic [VAL_W-1:0]  act_clr [NUM_CH],
  output logic [NUM_CH-1:0] en_mask,
  output logic              commit_pend
);

  logic [VAL_W-1:0] st_pre;
  logic [VAL_W-1:0] st_per;
  logic [VAL_W-1:0] st_set [NUM_CH];
  logic [VAL_W-1:0] st_clr [NUM_CH];
  logic             commit_wr;

  assign commit_wr = wr_en && (wr_addr == ADDR_W'(ADDR_COMMIT)) && wr_data[0];

  // Staging copy (the software-visible values)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pre  <= '0;
      st_per  <= '0;
      en_mask <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        st_set[c] <= '0;
        st_clr[c] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_PRESCALE)) st_pre  <= wr_data;
      if (wr_addr == ADDR_W'(ADDR_PERIOD))   st_per  <= wr_data;
      if (wr_addr == ADDR_W'(ADDR_ENABLE))   en_mask <= wr_data[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr == ADDR_W'(edge_addr(c, 1'b0))) st_set[c] <= wr_data;
        if (wr_addr == ADDR_W'(edge_addr(c, 1'b1))) st_clr[c] <= wr_data;
      end
    end
  end

  // Commit request flag; a same-cycle write overrides the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_pend <= 1'b0;
    end else begin
      if (wrap && commit_pend) commit_pend <= 1'b0;
      if (commit_wr && SHADOW_EN) commit_pend <= 1'b1;
    end
  end

  generate
    if (SHADOW_EN) begin : g_staged
      logic [VAL_W-1:0] lv_pre;
      logic [VAL_W-1:0] lv_per;
      logic [VAL_W-1:0] lv_set [NUM_CH];
      logic [VAL_W-1:0] lv_clr [NUM_CH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lv_pre <= '0;
          lv_per <= '0;
          for (int c = 0; c < NUM_CH; c++) begin
            lv_set[c] <= '0;
            lv_clr[c] <= '0;
          end
        end else if (wrap && commit_pend) begin
          lv_pre <= st_pre;
          lv_per <= st_per;
          for (int c = 0; c < NUM_CH; c++) begin
            lv_set[c] <= st_set[c];
            lv_clr[c] <= st_clr[c];
          end
        end
      end

      assign act_pre = lv_pre;
      assign act_per = lv_per;
      assign act_set = lv_set;
      assign act_clr = lv_clr;
    end else begin : g_direct
      assign act_pre = st_pre;
      assign act_per = st_per;
      assign act_set = st_set;
      assign act_clr = st_clr;
    end
  endgenerate

  // Read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_PRESCALE)) rd_data = st_pre;
    if (rd_addr == ADDR_W'(ADDR_PERIOD))   rd_data = st_per;
    if (rd_addr == ADDR_W'(ADDR_ENABLE))   rd_data = VAL_W'(en_mask);
    if (rd_addr == ADDR_W'(ADDR_COMMIT))   rd_data = VAL_W'(commit_pend);
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(edge_addr(c, 1'b0))) rd_data = st_set[c];
      if (rd_addr == ADDR_W'(edge_addr(c, 1'b1))) rd_data = st_clr[c];
    end
  end

endmodule

// File: rtl/edgepwm_timebase.sv
module edgepwm_timebase #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] act_pre,
  input  logic [VAL_W-1:0] act_per,
  output logic [VAL_W-1:0] pre_cnt,
  output logic [VAL_W-1:0] per_cnt,
  output logic             tick,
  output logic             wrap
);

  // ">=" so a direct-mode write that lowers a limit cannot strand a counter
  assign tick = (pre_cnt >= act_pre);
  assign wrap = tick && (per_cnt >= act_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (wrap)      per_cnt <= '0;
      else if (tick) per_cnt <= per_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/edgepwm_chan.sv
module edgepwm_chan
  import edgepwm_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [VAL_W-1:0] per_cnt,
  input  logic [VAL_W-1:0] act_per,
  input  logic [VAL_W-1:0] set_pt,
  input  logic [VAL_W-1:0] clr_pt,
  output logic             line
);

  logic hit_set;
  logic hit_clr;
  logic zero_duty;

  assign hit_set   = (per_cnt == set_pt);
  assign hit_clr   = (per_cnt == clr_pt);
  assign zero_duty = (clr_pt == '0) && (set_pt == act_per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line <= 1'b0;
    else if (!en)  line <= 1'b0;
    else if (tick) line <= next_level(line, hit_set, hit_clr, zero_duty);
  end

endmodule

// File: rtl/edgepwm_top.sv
module edgepwm_top #(
  parameter int NUM_CH    = 4,
  parameter int VAL_W     = 8,
  parameter int ADDR_W    = 4,
  parameter bit SHADOW_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [VAL_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int N_REGS = edgepwm_pkg::ADDR_EDGE_BASE + 2 * NUM_CH;

  initial begin
    if (N_REGS > (1 << ADDR_W)) $display("edgepwm_top: ADDR_W too small for NUM_CH");
  end

  logic [VAL_W-1:0]  act_pre;
  logic [VAL_W-1:0]  act_per;
  logic [VAL_W-1:0]  act_set [NUM_CH];
  logic [VAL_W-1:0]  act_clr [NUM_CH];
  logic [NUM_CH-1:0] en_mask;
  logic              commit_pend;
  logic [VAL_W-1:0]  pre_cnt;
  logic [VAL_W-1:0]  per_cnt;
  logic              tick;
  logic              wrap;

  edgepwm_regs #(
    .NUM_CH(NUM_CH), .VAL_W(VAL_W), .ADDR_W(ADDR_W), .SHADOW_EN(SHADOW_EN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wrap(wrap),
    .act_pre(act_pre), .act_per(act_per), .act_set(act_set), .act_clr(act_clr),
    .en_mask(en_mask), .commit_pend(commit_pend)
  );

  edgepwm_timebase #(.VAL_W(VAL_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .act_pre(act_pre), .act_per(act_per),
    .pre_cnt(pre_cnt), .per_cnt(per_cnt), .tick(tick), .wrap(wrap)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      edgepwm_chan #(.VAL_W(VAL_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .en(en_mask[i]), .tick(tick),
        .per_cnt(per_cnt), .act_per(act_per),
        .set_pt(act_set[i]), .clr_pt(act_clr[i]), .line(pwm_out[i])
      );
    end
  endgenerate

endmodule

// File: rtl/edgepwm_chk.sv
module edgepwm_chk #(
  parameter int NUM_CH    = 4,
  parameter int VAL_W     = 8,
  parameter bit SHADOW_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wrap,
  input logic [VAL_W-1:0]  pre_cnt,
  input logic [VAL_W-1:0]  per_cnt,
  input logic [VAL_W-1:0]  act_per,
  input logic [NUM_CH-1:0] en_mask,
  input logic [NUM_CH-1:0] pwm_out,
  input logic              commit_pend
);

  // R2
  prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_cnt == '0));

  // R2
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (per_cnt == '0));

  // R9
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(commit_pend) |-> $past(wrap));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      // R6
      disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[i] |=> !pwm_out[i]);

      // R3
      step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && en_mask[i]) |=> $stable(pwm_out[i]));
    end

    if (SHADOW_EN) begin : g_staged
      // R8
      live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_per));
    end else begin : g_direct
      // R7
      no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_pend);
    end
  endgenerate

endmodule

bind edgepwm_top edgepwm_chk #(
  .NUM_CH(NUM_CH), .VAL_W(VAL_W), .SHADOW_EN(SHADOW_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .pre_cnt(pre_cnt),
  .per_cnt(per_cnt), .act_per(act_per), .en_mask(en_mask), .pwm_out(pwm_out),
  .commit_pend(commit_pend)
);

// File: tb/edgepwm_top_tb.sv
`timescale 1ns/1ps
module edgepwm_top_tb;
  import edgepwm_pkg::*;

  localparam int NCH = 4;
  localparam int VW  = 8;
  localparam int AW  = 4;
  localparam int NROW = 6;
  // pre, per, set, clr, high steps in 4 periods, rising edges in 4 periods
  localparam int TBL [NROW][6] = '{
    '{0, 7, 2, 5, 12, 4},   // R3 set below clear
    '{1, 9, 1, 8, 28, 4},   // R3 R2 prescaled
    '{2, 5, 4, 1, 12, 4},   // R3 high time wraps through zero
    '{0, 7, 3, 3, 16, 2},   // R4 equal points toggle
    '{1, 6, 6, 0,  0, 0},   // R5 zero duty
    '{3, 4, 0, 2,  8, 4}    // R2 R3
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [VW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [VW-1:0] rd_sh, rd_im;
  logic [NCH-1:0] pwm_sh, pwm_im;
  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  edgepwm_top #(.NUM_CH(NCH), .VAL_W(VW), .ADDR_W(AW), .SHADOW_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_sh), .pwm_out(pwm_sh));

  edgepwm_top #(.NUM_CH(NCH), .VAL_W(VW), .ADDR_W(AW), .SHADOW_EN(1'b0)) u_imm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_im), .pwm_out(pwm_im));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = VW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input int ch, input int pre, input int per, input int s, input int c);
    wr(ADDR_PRESCALE, pre);
    wr(ADDR_PERIOD, per);
    wr(edge_addr(ch, 1'b0), s);
    wr(edge_addr(ch, 1'b1), c);
  endtask

  task automatic commit(output int first_sh, output int first_im, output int cycles);
    rd_addr = AW'(ADDR_COMMIT);
    wr(ADDR_COMMIT, 1);
    first_sh = int'(rd_sh);
    first_im = int'(rd_im);
    cycles = 0;
    while (rd_sh != '0 && cycles < 5000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int ch, input int win,
                         output int hs, output int es, output int hi, output int ei);
    logic ps, pi;
    ps = pwm_sh[ch]; pi = pwm_im[ch];
    hs = 0; es = 0; hi = 0; ei = 0;
    repeat (win) begin
      @(negedge clk);
      if (pwm_sh[ch]) hs++;
      if (pwm_im[ch]) hi++;
      if (pwm_sh[ch] && !ps) es++;
      if (pwm_im[ch] && !pi) ei++;
      ps = pwm_sh[ch]; pi = pwm_im[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hs, es, hi, ei, f_sh, f_im, cyc, step;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = AW'(ADDR_COMMIT);
    idle(5);
    // R1 reset state
    check("R1 lines staged", int'(pwm_sh), 0);
    check("R1 lines direct", int'(pwm_im), 0);
    check("R1 commit flag", int'(rd_sh), 0);
    rd_addr = AW'(ADDR_PERIOD);
    #1;
    check("R1 period reg", int'(rd_sh), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(10);
    check("R1 lines stay low while disabled", int'(pwm_sh | pwm_im), 0);

    wr(ADDR_ENABLE, 1);
    for (int r = 0; r < NROW; r++) begin
      step = TBL[r][0] + 1;
      prog(0, TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3]);
      commit(f_sh, f_im, cyc);
      idle(2 * (TBL[r][1] + 1) * step + 8);
      measure(0, 4 * (TBL[r][1] + 1) * step, hs, es, hi, ei);
      check($sformatf("R3 R4 R5 high cycles staged row %0d", r), hs, TBL[r][4] * step);
      check($sformatf("R2 R4 edges staged row %0d", r), es, TBL[r][5]);
      check($sformatf("R7 high cycles direct row %0d", r), hi, TBL[r][4] * step);
      check($sformatf("R7 edges direct row %0d", r), ei, TBL[r][5]);
    end

    // R9 commit flag lifetime, R7 flag absent in direct mode
    prog(0, 3, 20, 5, 10);
    commit(f_sh, f_im, cyc);
    check("R9 flag set after commit write", f_sh, 1);
    check("R7 direct flag reads 0", f_im, 0);
    check("R9 flag clears within one period", (cyc <= 4 * 21 + 2) ? 1 : 0, 1);
    check("R9 flag reads 0 after copy", int'(rd_sh), 0);

    // R8 staged hold versus R7 direct effect
    prog(0, 0, 9, 2, 7);
    commit(f_sh, f_im, cyc);
    idle(28);
    measure(0, 40, hs, es, hi, ei);
    check("R3 base high staged", hs, 20);
    wr(edge_addr(0, 1'b1), 4);
    idle(28);
    measure(0, 40, hs, es, hi, ei);
    check("R8 uncommitted write ignored", hs, 20);
    check("R7 write acts at once", hi, 8);
    commit(f_sh, f_im, cyc);
    idle(28);
    measure(0, 40, hs, es, hi, ei);
    check("R8 committed write applied", hs, 8);

    // R2 shared timebase and R6 per-channel enable
    wr(edge_addr(1, 1'b0), 5);
    wr(edge_addr(1, 1'b1), 8);
    commit(f_sh, f_im, cyc);
    wr(ADDR_ENABLE, 3);
    idle(28);
    measure(1, 40, hs, es, hi, ei);
    check("R2 channel 1 edges shared period", es, 4);
    check("R3 channel 1 high", hs, 12);
    measure(0, 40, hs, es, hi, ei);
    check("R2 channel 0 edges shared period", es, 4);
    wr(ADDR_ENABLE, 2);
    idle(2);
    measure(0, 40, hs, es, hi, ei);
    check("R6 disabled channel high staged", hs, 0);
    check("R6 disabled channel high direct", hi, 0);
    measure(1, 40, hs, es, hi, ei);
    check("R6 other channel unaffected", es, 4);

    // R10 readback
    rd_addr = AW'(edge_addr(1, 1'b1)); #1;
    check("R10 clear-point readback", int'(rd_sh), 8);
    rd_addr = AW'(ADDR_ENABLE); #1;
    check("R10 enable readback", int'(rd_sh), 2);
    rd_addr = AW'(ADDR_PERIOD); #1;
    check("R10 period readback", int'(rd_sh), 9);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule